// File: doc/BRIEF.md
# Battery-Tracking Limiter Threshold Generator

This block turns a battery-voltage sample into the threshold that an audio peak limiter works against. It then compares the current output peak level with that threshold. While the battery is at or above a programmable knee voltage, the threshold stays at a programmable ceiling. Below the knee, the threshold falls in proportion to how far the battery is under the knee, using one of four selectable slopes. A programmable floor stops the fall.

Alongside the limiter path, a separate comparator checks the same battery sample against a brown-out level. That level has its own, finer code scale. Voltages arrive as millivolt codes together with a single valid strobe. The threshold and both request flags are registered. They change only on the clock edge that takes in a valid sample, and they hold their values between samples.

Top module: `lim_thresh_gen`

## Requirements
- R1: The ceiling, floor and knee codes are 7 bits wide, and each decodes to 2000 mV + 100 mV × code (0x00 = 2000 mV, 0x7F = 14700 mV).
- R2: When the battery sample is greater than or equal to the knee, the threshold equals the ceiling.
- R3: When the battery is below the knee, the threshold is lowered by d × slope, where d = knee − battery. The slope code maps as follows: 0 gives d, 1 gives d + floor(d/2), 2 gives 2d and 3 gives 4d.
- R4: A lowered threshold never goes under the floor. When the reduction reaches or exceeds ceiling − floor, the threshold equals the floor.
- R5: The threshold never exceeds the ceiling. When the floor is programmed above the ceiling, the threshold equals the ceiling.
- R6: The 8-bit brown-out code decodes to 4500 mV + 25 mV × code. brownReq is 1 exactly when the battery is strictly below that level.
- R7: limitReq is 1 exactly when the peak input is strictly greater than the threshold computed from the same sample.
- R8: All three outputs update on the clock edge that samples sampleValid high, so they are visible one cycle after the strobe. With sampleValid low, the outputs hold their values whatever the other inputs do.
- R9: After reset, threshMv is 0, and limitReq and brownReq are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sampleValid | input | 1 | Marks a new battery/peak sample |
| batMv | input | 16 | Battery voltage, mV |
| peakMv | input | 16 | Output peak level, mV |
| ceilCode | input | 7 | Threshold ceiling code |
| floorCode | input | 7 | Threshold floor code |
| kneeCode | input | 7 | Knee (tracking start) code |
| slopeSel | input | 2 | Tracking slope select |
| brownCode | input | 8 | Brown-out level code |
| threshMv | output | 16 | Active limiter threshold, mV |
| limitReq | output | 1 | Peak above threshold |
| brownReq | output | 1 | Battery below brown-out level |

## Verification
The bench targets the edges of every comparison. These are a battery exactly at the knee, a peak exactly equal to the threshold, a battery exactly at the brown-out level, and a reduction that lands exactly on the floor. A design that used the wrong inequality at any of these points would flip the matching output. An odd drop under the 1.5 V/V slope exposes a design that rounds the half-step instead of truncating it. A floor set above the ceiling catches a design that lets the clamp outrank the ceiling. A zero battery with the 4 V/V slope catches a design whose reduction width overflows and wraps to a bogus high threshold. Changing the inputs with the strobe low catches outputs that follow the inputs instead of holding.

// File: rtl/lim_thresh_pkg.sv
package lim_thresh_pkg;

  // which source the next threshold is taken from
  typedef enum logic [1:0] {
    SEL_CEIL  = 2'd0,
    SEL_TRACK = 2'd1,
    SEL_FLOOR = 2'd2
  } thrSel_e;

  // comparison results reported by the datapath
  typedef struct packed {
    logic belowKnee;
    logic floorHit;
    logic floorOverCeil;
  } dpFlags_t;

  // strobes from control into the datapath
  typedef struct packed {
    logic    capture;
    thrSel_e sel;
  } ctrlStb_t;

endpackage

// File: rtl/lim_thresh_ctrl.sv
module lim_thresh_ctrl
  import lim_thresh_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     sampleValid,
  input  dpFlags_t flags,
  output ctrlStb_t stb
);

  always_comb begin
    stb.capture = sampleValid;
    if (flags.floorOverCeil || !flags.belowKnee) begin
      stb.sel = SEL_CEIL;
    end else if (flags.floorHit) begin
      stb.sel = SEL_FLOOR;
    end else begin
      stb.sel = SEL_TRACK;
    end
  end

  // the select encoding must stay within its three legal values (R3)
  assert_sel_legal_R3: assert property (@(posedge clk) disable iff (!rstN)
    stb.capture |-> (stb.sel != 2'd3));

endmodule

// File: rtl/lim_thresh_dp.sv
module lim_thresh_dp
  import lim_thresh_pkg::*;
#(
  parameter int MV_W        = 16,
  parameter int THR_CODE_W  = 7,
  parameter int BRN_CODE_W  = 8,
  parameter int THR_BASE_MV = 2000,
  parameter int THR_STEP_MV = 100,
  parameter int BRN_BASE_MV = 4500,
  parameter int BRN_STEP_MV = 25
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  sampleValid,
  input  logic [MV_W-1:0]       batMv,
  input  logic [MV_W-1:0]       peakMv,
  input  logic [THR_CODE_W-1:0] ceilCode,
  input  logic [THR_CODE_W-1:0] floorCode,
  input  logic [THR_CODE_W-1:0] kneeCode,
  input  logic [1:0]            slopeSel,
  input  logic [BRN_CODE_W-1:0] brownCode,
  input  ctrlStb_t              stb,
  output dpFlags_t              flags,
  output logic [MV_W-1:0]       threshMv,
  output logic                  limitReq,
  output logic                  brownReq
);

  // two extra bits cover the 4x slope applied to a full-range drop
  localparam int SC_W = MV_W + 2;

  logic [MV_W-1:0] ceilMv, floorMv, kneeMv, brownMv;
  logic [MV_W-1:0] dropMv, spanMv, trackMv, nextThr;
  logic [SC_W-1:0] dropExt, scaledDrop;

  // code-to-millivolt decoding
  assign ceilMv  = MV_W'(THR_BASE_MV) + MV_W'(THR_STEP_MV) * MV_W'(ceilCode);
  assign floorMv = MV_W'(THR_BASE_MV) + MV_W'(THR_STEP_MV) * MV_W'(floorCode);
  assign kneeMv  = MV_W'(THR_BASE_MV) + MV_W'(THR_STEP_MV) * MV_W'(kneeCode);
  assign brownMv = MV_W'(BRN_BASE_MV) + MV_W'(BRN_STEP_MV) * MV_W'(brownCode);

  assign dropMv  = kneeMv - batMv;
  assign dropExt = SC_W'(dropMv);
  assign spanMv  = ceilMv - floorMv;

  // slope scaling using shifts only
  always_comb begin
    unique case (slopeSel)
      2'd0:    scaledDrop = dropExt;
      2'd1:    scaledDrop = dropExt + (dropExt >> 1);
      2'd2:    scaledDrop = dropExt << 1;
      default: scaledDrop = dropExt << 2;
    endcase
  end

  assign flags.belowKnee     = batMv < kneeMv;
  assign flags.floorOverCeil = floorMv > ceilMv;
  assign flags.floorHit      = scaledDrop >= SC_W'(spanMv);

  assign trackMv = ceilMv - scaledDrop[MV_W-1:0];

  always_comb begin
    unique case (stb.sel)
      SEL_TRACK: nextThr = trackMv;
      SEL_FLOOR: nextThr = floorMv;
      default:   nextThr = ceilMv;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      threshMv <= '0;
      limitReq <= 1'b0;
      brownReq <= 1'b0;
    end else if (stb.capture) begin
      threshMv <= nextThr;
      limitReq <= peakMv > nextThr;
      brownReq <= batMv < brownMv;
    end
  end

  assert_thr_le_ceil_R5: assert property (@(posedge clk) disable iff (!rstN)
    $past(sampleValid) |-> (threshMv <= $past(ceilMv)));

  assert_thr_ge_floor_R4: assert property (@(posedge clk) disable iff (!rstN)
    ($past(sampleValid) && !$past(flags.floorOverCeil)) |-> (threshMv >= $past(floorMv)));

  assert_flat_above_knee_R2: assert property (@(posedge clk) disable iff (!rstN)
    ($past(sampleValid) && ($past(batMv) >= $past(kneeMv))) |-> (threshMv == $past(ceilMv)));

  assert_hold_no_strobe_R8: assert property (@(posedge clk) disable iff (!rstN)
    !$past(sampleValid) |-> ($stable(threshMv) && $stable(limitReq) && $stable(brownReq)));

  assert_brown_cmp_R6: assert property (@(posedge clk) disable iff (!rstN)
    $past(sampleValid) |-> (brownReq == ($past(batMv) < $past(brownMv))));

endmodule

// File: rtl/lim_thresh_gen.sv
module lim_thresh_gen
  import lim_thresh_pkg::*;
#(
  parameter int MV_W       = 16,
  parameter int THR_CODE_W = 7,
  parameter int BRN_CODE_W = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  sampleValid,
  input  logic [MV_W-1:0]       batMv,
  input  logic [MV_W-1:0]       peakMv,
  input  logic [THR_CODE_W-1:0] ceilCode,
  input  logic [THR_CODE_W-1:0] floorCode,
  input  logic [THR_CODE_W-1:0] kneeCode,
  input  logic [1:0]            slopeSel,
  input  logic [BRN_CODE_W-1:0] brownCode,
  output logic [MV_W-1:0]       threshMv,
  output logic                  limitReq,
  output logic                  brownReq
);

  dpFlags_t flags;
  ctrlStb_t stb;

  lim_thresh_ctrl uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .sampleValid(sampleValid),
    .flags      (flags),
    .stb        (stb)
  );

  lim_thresh_dp #(
    .MV_W      (MV_W),
    .THR_CODE_W(THR_CODE_W),
    .BRN_CODE_W(BRN_CODE_W)
  ) uDp (
    .clk        (clk),
    .rstN       (rstN),
    .sampleValid(sampleValid),
    .batMv      (batMv),
    .peakMv     (peakMv),
    .ceilCode   (ceilCode),
    .floorCode  (floorCode),
    .kneeCode   (kneeCode),
    .slopeSel   (slopeSel),
    .brownCode  (brownCode),
    .stb        (stb),
    .flags      (flags),
    .threshMv   (threshMv),
    .limitReq   (limitReq),
    .brownReq   (brownReq)
  );

endmodule

// File: tb/lim_thresh_gen_test.sv
module lim_thresh_gen_test;

  typedef struct packed {
    logic [15:0] bat;
    logic [15:0] peak;
    logic [6:0]  ceilC;
    logic [6:0]  floorC;
    logic [6:0]  kneeC;
    logic [1:0]  slope;
    logic [7:0]  brownC;
    logic [15:0] expThr;
    logic        expLim;
    logic        expBrown;
  } vec_t;

  localparam int NV = 16;

  // ceiling 0x6E=13000, floor 0x1E=5000, knee 0x58=10800 unless noted
  localparam vec_t VECS [NV] = '{
    '{16'd12000, 16'd12000, 7'h6E, 7'h1E, 7'h58, 2'd0, 8'h14, 16'd13000, 1'b0, 1'b0}, // R2 above knee
    '{16'd10800, 16'd13001, 7'h6E, 7'h1E, 7'h58, 2'd0, 8'h14, 16'd13000, 1'b1, 1'b0}, // R2 at knee, R7
    '{16'd9800,  16'd12000, 7'h6E, 7'h1E, 7'h58, 2'd0, 8'h14, 16'd12000, 1'b0, 1'b0}, // R3 1x, R7 equal
    '{16'd9800,  16'd11501, 7'h6E, 7'h1E, 7'h58, 2'd1, 8'h14, 16'd11500, 1'b1, 1'b0}, // R3 1.5x
    '{16'd9800,  16'd0,     7'h6E, 7'h1E, 7'h58, 2'd2, 8'h14, 16'd11000, 1'b0, 1'b0}, // R3 2x
    '{16'd9800,  16'd9001,  7'h6E, 7'h1E, 7'h58, 2'd3, 8'h14, 16'd9000,  1'b1, 1'b0}, // R3 4x
    '{16'd9799,  16'd11499, 7'h6E, 7'h1E, 7'h58, 2'd1, 8'h14, 16'd11499, 1'b0, 1'b0}, // R3 odd drop truncates
    '{16'd7000,  16'd9000,  7'h6E, 7'h1E, 7'h58, 2'd0, 8'h14, 16'd9200,  1'b0, 1'b0}, // R3 deep 1x
    '{16'd6000,  16'd5001,  7'h6E, 7'h1E, 7'h58, 2'd3, 8'h14, 16'd5000,  1'b1, 1'b0}, // R4 clamp
    '{16'd4999,  16'd0,     7'h6E, 7'h1E, 7'h58, 2'd0, 8'h14, 16'd7199,  1'b0, 1'b1}, // R6 just below
    '{16'd5000,  16'd0,     7'h6E, 7'h1E, 7'h58, 2'd0, 8'h14, 16'd7200,  1'b0, 1'b0}, // R6 equal
    '{16'd6000,  16'd13000, 7'h6E, 7'h7F, 7'h58, 2'd0, 8'hFF, 16'd13000, 1'b0, 1'b1}, // R5 floor>ceil, R6 top code
    '{16'd2000,  16'd2001,  7'h00, 7'h00, 7'h00, 2'd0, 8'h00, 16'd2000,  1'b1, 1'b1}, // R1 zero codes
    '{16'd14200, 16'd0,     7'h7F, 7'h1E, 7'h7F, 2'd2, 8'hFF, 16'd13700, 1'b0, 1'b0}, // R1 top codes
    '{16'd6800,  16'd5000,  7'h6E, 7'h1E, 7'h58, 2'd2, 8'h14, 16'd5000,  1'b0, 1'b0}, // R4 exact floor
    '{16'd0,     16'd0,     7'h7F, 7'h00, 7'h7F, 2'd3, 8'h00, 16'd2000,  1'b0, 1'b1}  // R4 wide drop
  };

  localparam string TAGS [NV] = '{
    "R2", "R2", "R3", "R3", "R3", "R3", "R3", "R3",
    "R4", "R6", "R6", "R5", "R1", "R1", "R4", "R4"
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        sampleValid = 1'b0;
  logic [15:0] batMv = '0, peakMv = '0;
  logic [6:0]  ceilCode = 7'h6E, floorCode = 7'h1E, kneeCode = 7'h58;
  logic [1:0]  slopeSel = 2'd0;
  logic [7:0]  brownCode = 8'h14;
  logic [15:0] threshMv;
  logic        limitReq, brownReq;

  int nChecks = 0;
  int nFail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  lim_thresh_gen uut (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid),
    .batMv(batMv), .peakMv(peakMv),
    .ceilCode(ceilCode), .floorCode(floorCode), .kneeCode(kneeCode),
    .slopeSel(slopeSel), .brownCode(brownCode),
    .threshMv(threshMv), .limitReq(limitReq), .brownReq(brownReq)
  );

  task automatic check(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    batMv = v.bat; peakMv = v.peak;
    ceilCode = v.ceilC; floorCode = v.floorC; kneeCode = v.kneeC;
    slopeSel = v.slope; brownCode = v.brownC;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R9 threshMv reset", threshMv, 0);
    check("R9 limitReq reset", limitReq, 0);
    check("R9 brownReq reset", brownReq, 0);
    rstN = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      drive(VECS[i]);
      sampleValid = 1'b1;
      @(negedge clk);
      sampleValid = 1'b0;
      check({TAGS[i], " threshMv"}, threshMv, VECS[i].expThr);
      check("R7 limitReq", limitReq, VECS[i].expLim);
      check("R6 brownReq", brownReq, VECS[i].expBrown);
    end

    // R8: change inputs without the strobe, outputs must hold (last: 2000/0/1)
    drive(VECS[0]);
    repeat (3) @(negedge clk);
    check("R8 hold threshMv", threshMv, 2000);
    check("R8 hold limitReq", limitReq, 0);
    check("R8 hold brownReq", brownReq, 1);

    // R8: one cycle latency; before the edge the old value is still present
    sampleValid = 1'b1;
    @(posedge clk);
    #1 sampleValid = 1'b0;
    check("R8 latency threshMv", threshMv, 13000);
    check("R8 latency brownReq", brownReq, 0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", nChecks, nFail);
      $finish;
    end
  end

endmodule